// File: doc/BRIEF.md
# LIN Synch Field Baud Resynchronizer

This block retunes the receive baud divider of a LIN slave to the bit rate of the master. After each break, the master sends the 0x55 synch byte. The block times the span from the first to the fifth falling edge of that byte on the synchronized receive line, which covers exactly eight bit periods. From that count it computes a new fractional divider. The divider is 16 bits wide: bits [15:4] hold the integer part and bits [3:0] hold sixteenths. One bit period equals 16 × divider peripheral clocks.

Three divider copies are kept. The nominal copy follows the value written by software, the measured copy holds the last accepted synch result, and the active value feeds the baud tick generator. Before a measured value is accepted, it is checked against the nominal one. A deviation that is too large, an invalid result or a stalled measurement raises a header error, and the active divider is left unchanged.

While a measurement runs, a busy flag holds the frame state machine. A completed frame or an error or idle transition returns the active divider to nominal.

Top module: `lin_sync_resync`

## Requirements
- R1: During and directly after reset, `meas_busy_o`, `meas_done_o` and `hdr_err_o` are low and `div_o` is zero. The nominal copy is loaded from `nom_div_i` at the first clock edge after reset release.
- R2: A `brk_det_i` strobe with `resync_en_i` high sets `meas_busy_o` from the next cycle until the measurement ends. With `resync_en_i` low, the strobe is ignored: `meas_busy_o` stays low and no done strobe follows.
- R3: The count SM is the number of clock cycles between the sample of the first falling edge of `rx_i` and the sample of the fifth. `meas_done_o` pulses for one cycle in the cycle after the fifth edge is sampled, and `meas_busy_o` falls in that same cycle.
- R4: The measured divider is (SM + 4) >> 3, which is SM/128 rounded to the nearest 1/16. When accepted, it appears on `div_o` together with `meas_done_o`. With bit periods of P cycles, `div_o` becomes P.
- R5: If |measured − nominal| × 128 ≥ 19 × nominal, `hdr_err_o` pulses together with `meas_done_o`, the result is discarded, and `div_o` keeps its previous value.
- R6: A result whose integer part (bits [15:4]) is zero, or which does not fit in 16 bits, is rejected in the same way as R5.
- R7: If the cycle counter reaches its maximum before the fifth edge, the measurement ends with `meas_done_o` and `hdr_err_o` both high, and the divider is not changed.
- R8: A `frame_done_i` or `err_idle_i` pulse returns `div_o` to the nominal value. `err_idle_i` also cancels a measurement in progress without a done strobe.
- R9: When no measurement is in progress, the nominal copy follows `nom_div_i` with one cycle of latency. During a measurement it is frozen, and both `div_o` and the deviation check use the frozen value.
- R10: While `resync_en_i` is low, `div_o` shows the nominal copy, even if a measured value was accepted earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Synchronized receive line, idle high |
| resync_en_i | input | 1 | Enables automatic resynchronization |
| brk_det_i | input | 1 | One-cycle strobe: break detected |
| nom_div_i | input | 16 | Nominal divider from software (12.4 fixed point) |
| frame_done_i | input | 1 | One-cycle strobe: complete frame received |
| err_idle_i | input | 1 | One-cycle strobe: frame logic fell to idle, break or delimiter on error |
| div_o | output | 16 | Active divider for the baud tick generator |
| meas_busy_o | output | 1 | Synch field measurement in progress; holds the frame state machine |
| meas_done_o | output | 1 | One-cycle strobe: measurement finished |
| hdr_err_o | output | 1 | Header error, pulses with `meas_done_o` |

## Verification
The bench builds the block with a 12-bit cycle counter, not the default 19 bits. Counter saturation then takes about four thousand cycles, so the abort path can be reached in a short run. Bit periods of 15 to 170 cycles keep every synch count inside that counter.

With a nominal value of 128, the deviation limit falls on whole measured values. This makes both sides of the threshold visible: 146 and 110 are accepted, while 147 and 109 are rejected. A nominal value of 14 with a measured value of 15 reaches the zero-integer rejection without triggering the deviation check.

// File: rtl/lsr_pkg.sv
`timescale 1ns/1ps
package lsr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_COUNT = 2'd2
  } meas_st_e;
endpackage

// File: rtl/lsr_edge_meas.sv
`timescale 1ns/1ps
module lsr_edge_meas
  import lsr_pkg::*;
#(
  parameter int CNT_W = 19,
  parameter int EDGES = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  input  logic             en_i,
  input  logic             brk_i,
  input  logic             abort_i,
  output logic             busy_o,
  output logic             fin_o,
  output logic             sat_o,
  output logic [CNT_W-1:0] sm_o
);
  localparam int EC_W = $clog2(EDGES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [EC_W-1:0]  LAST_EDGE = EC_W'(EDGES - 1);

  meas_st_e         st_q;
  logic             rx_q;
  logic [CNT_W-1:0] cnt_q;
  logic [EC_W-1:0]  edge_q;
  logic             fall, start, last_fall, cnt_full;

  assign fall      = rx_q & ~rx_i;
  assign start     = brk_i & en_i;
  assign last_fall = fall && (edge_q == LAST_EDGE);
  assign cnt_full  = (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q   <= 1'b1;
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      edge_q <= '0;
    end else begin
      rx_q <= rx_i;
      if (abort_i) begin
        st_q <= ST_IDLE;
      end else if (start) begin
        st_q   <= ST_ARMED;
        cnt_q  <= '0;
        edge_q <= '0;
      end else begin
        unique case (st_q)
          ST_ARMED: if (fall) begin
            st_q   <= ST_COUNT;
            cnt_q  <= CNT_W'(1);
            edge_q <= EC_W'(1);
          end
          ST_COUNT: begin
            if (last_fall || cnt_full) begin
              st_q <= ST_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
              if (fall) edge_q <= edge_q + 1'b1;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign fin_o  = (st_q == ST_COUNT) && last_fall && !abort_i && !start;
  assign sat_o  = (st_q == ST_COUNT) && !last_fall && cnt_full && !abort_i && !start;
  assign sm_o   = cnt_q;

  // counter must never wrap back into a running measurement
  assert_no_wrap_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_COUNT && cnt_full) |=> (st_q != ST_COUNT));
endmodule

// File: rtl/lsr_div_eval.sv
`timescale 1ns/1ps
module lsr_div_eval #(
  parameter int CNT_W      = 19,
  parameter int DIV_W      = 16,
  parameter int FRAC_W     = 4,
  parameter int MEAS_SHIFT = 7,
  parameter int DEV_NUM    = 19
) (
  input  logic [CNT_W-1:0] sm_i,
  input  logic [DIV_W-1:0] nom_i,
  output logic [DIV_W-1:0] raw_o,
  output logic             bad_o,
  output logic             dev_o
);
  localparam int SH    = MEAS_SHIFT - FRAC_W;
  localparam int EXT_W = CNT_W + DIV_W;
  localparam int CMP_W = DIV_W + MEAS_SHIFT + 2;
  localparam logic [EXT_W-1:0] RND = EXT_W'(1) << (SH - 1);

  logic [EXT_W-1:0] sum, quo;
  logic [DIV_W-1:0] diff;
  logic [CMP_W-1:0] lhs, rhs;
  logic             ovf, zero_int;

  always_comb begin
    sum      = EXT_W'(sm_i) + RND;
    quo      = sum >> SH;
    ovf      = |quo[EXT_W-1:DIV_W];
    raw_o    = quo[DIV_W-1:0];
    zero_int = (raw_o[DIV_W-1:FRAC_W] == '0);
    diff     = (raw_o >= nom_i) ? (raw_o - nom_i) : (nom_i - raw_o);
    lhs      = CMP_W'(diff) << MEAS_SHIFT;
    rhs      = CMP_W'(nom_i) * CMP_W'(DEV_NUM);
    dev_o    = (lhs >= rhs);
    bad_o    = ovf | zero_int;
  end
endmodule

// File: rtl/lsr_div_bank.sv
`timescale 1ns/1ps
module lsr_div_bank #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             busy_i,
  input  logic             fin_i,
  input  logic             sat_i,
  input  logic             bad_i,
  input  logic             dev_i,
  input  logic             reload_i,
  input  logic [DIV_W-1:0] raw_i,
  input  logic [DIV_W-1:0] nom_div_i,
  output logic [DIV_W-1:0] nom_o,
  output logic [DIV_W-1:0] div_o,
  output logic             done_o,
  output logic             err_o
);
  logic [DIV_W-1:0] nom_q, meas_q;
  logic             tuned_q, done_q, err_q, upd;

  assign upd = fin_i & ~bad_i & ~dev_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nom_q   <= '0;
      meas_q  <= '0;
      tuned_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (!busy_i) nom_q <= nom_div_i;
      if (upd) meas_q <= raw_i;
      if (upd)           tuned_q <= 1'b1;
      else if (reload_i) tuned_q <= 1'b0;
      done_q <= fin_i | sat_i;
      err_q  <= sat_i | (fin_i & (bad_i | dev_i));
    end
  end

  assign nom_o  = nom_q;
  assign div_o  = (en_i && tuned_q) ? meas_q : nom_q;
  assign done_o = done_q;
  assign err_o  = err_q;

  // rejected result leaves the active divider untouched
  assert_err_keeps_div_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && en_i && $past(en_i) && !$past(reload_i)) |-> $stable(div_o));
endmodule

// File: rtl/lin_sync_resync.sv
`timescale 1ns/1ps
module lin_sync_resync #(
  parameter int CNT_W      = 19,
  parameter int MANT_W     = 12,
  parameter int FRAC_W     = 4,
  parameter int EDGES      = 5,
  parameter int MEAS_SHIFT = 7,
  parameter int DEV_NUM    = 19,
  localparam int DIV_W     = MANT_W + FRAC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  input  logic             resync_en_i,
  input  logic             brk_det_i,
  input  logic [DIV_W-1:0] nom_div_i,
  input  logic             frame_done_i,
  input  logic             err_idle_i,
  output logic [DIV_W-1:0] div_o,
  output logic             meas_busy_o,
  output logic             meas_done_o,
  output logic             hdr_err_o
);
  logic             busy, fin, sat, bad, dev;
  logic [CNT_W-1:0] sm;
  logic [DIV_W-1:0] raw, nom;

  lsr_edge_meas #(.CNT_W(CNT_W), .EDGES(EDGES)) u_meas (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rx_i    (rx_i),
    .en_i    (resync_en_i),
    .brk_i   (brk_det_i),
    .abort_i (err_idle_i),
    .busy_o  (busy),
    .fin_o   (fin),
    .sat_o   (sat),
    .sm_o    (sm)
  );

  lsr_div_eval #(
    .CNT_W(CNT_W), .DIV_W(DIV_W), .FRAC_W(FRAC_W),
    .MEAS_SHIFT(MEAS_SHIFT), .DEV_NUM(DEV_NUM)
  ) u_eval (
    .sm_i  (sm),
    .nom_i (nom),
    .raw_o (raw),
    .bad_o (bad),
    .dev_o (dev)
  );

  lsr_div_bank #(.DIV_W(DIV_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (resync_en_i),
    .busy_i    (busy),
    .fin_i     (fin),
    .sat_i     (sat),
    .bad_i     (bad),
    .dev_i     (dev),
    .reload_i  (frame_done_i | err_idle_i),
    .raw_i     (raw),
    .nom_div_i (nom_div_i),
    .nom_o     (nom),
    .div_o     (div_o),
    .done_o    (meas_done_o),
    .err_o     (hdr_err_o)
  );

  assign meas_busy_o = busy;

  assert_done_ends_busy_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_done_o |-> ($past(meas_busy_o) && !meas_busy_o));

  assert_err_with_done_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_err_o |-> meas_done_o);

  assert_idle_when_off_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!resync_en_i && !meas_busy_o) |=> !meas_busy_o);
endmodule

// File: tb/lin_sync_resync_tb.sv
`timescale 1ns/1ps
module lin_sync_resync_tb;
  localparam int CNT_W = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx = 1'b1, en = 1'b1, brk = 1'b0, fdone = 1'b0, eidle = 1'b0;
  logic [15:0] nom = 16'd160;
  logic [15:0] div_o;
  logic        busy_o, done_o, err_o;

  int n_chk = 0, n_bad = 0;
  int cyc = 0, done_n = 0, done_cyc = 0, e5_cyc = 0;
  logic done_err = 1'b0;

  always #4 clk = ~clk;

  lin_sync_resync #(.CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .resync_en_i(en), .brk_det_i(brk),
    .nom_div_i(nom), .frame_done_i(fdone), .err_idle_i(eidle),
    .div_o(div_o), .meas_busy_o(busy_o), .meas_done_o(done_o), .hdr_err_o(err_o)
  );

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (done_o) begin
    done_n++; done_cyc = cyc; done_err = err_o;
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_brk();
    @(negedge clk) brk = 1'b1;
    @(negedge clk) brk = 1'b0;
    wait_cyc(2);
  endtask

  // 0x55 frame: start, 1,0,1,0,1,0,1,0, stop; falls at bits 0,2,4,6,8
  task automatic send_sync(input int p, output logic busy_mid);
    logic [9:0] pat = 10'b1_0101_0101_0;
    busy_mid = 1'b0;
    for (int b = 0; b < 10; b++) begin
      rx = pat[b];
      if (b == 8) e5_cyc = cyc;
      for (int k = 0; k < p; k++) begin
        @(negedge clk);
        if (b == 4 && k == 0) busy_mid = busy_o;
      end
    end
    rx = 1'b1;
    wait_cyc(3);
  endtask

  task automatic set_nom(input logic [15:0] v);
    nom = v;
    wait_cyc(2);
  endtask

  task automatic reload_frame();
    @(negedge clk) fdone = 1'b1;
    @(negedge clk) fdone = 1'b0;
    wait_cyc(1);
  endtask

  task automatic reload_err();
    @(negedge clk) eidle = 1'b1;
    @(negedge clk) eidle = 1'b0;
    wait_cyc(1);
  endtask

  task automatic measure(input int p, input logic exp_err, input logic [15:0] exp_div, input string req);
    int d0;
    logic bm;
    d0 = done_n;
    pulse_brk();
    send_sync(p, bm);
    chk(req, "done count", done_n - d0, 1);
    chk(req, "header error", done_err, exp_err);
    chk(req, "divider", div_o, exp_div);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    #1;
    chk("R1", "busy after reset", busy_o, 0);
    chk("R1", "done after reset", done_o, 0);
    chk("R1", "err after reset", err_o, 0);
    chk("R1", "div after reset", div_o, 0);
    wait_cyc(1);
    chk("R1", "div loads nominal", div_o, 160);
  endtask

  task automatic t_match();
    int d0;
    logic bm;
    d0 = done_n;
    pulse_brk();
    chk("R2", "busy after break", busy_o, 1);
    send_sync(160, bm);
    chk("R2", "busy mid field", bm, 1);
    chk("R3", "done once", done_n - d0, 1);
    chk("R3", "done cycle after fifth edge", done_cyc - e5_cyc, 1);
    chk("R3", "busy cleared", busy_o, 0);
    chk("R4", "div for P=160", div_o, 160);
    chk("R5", "no error at match", done_err, 0);
  endtask

  task automatic t_retune();
    measure(170, 1'b0, 16'd170, "R4");
    reload_frame();
    chk("R8", "frame reload to nominal", div_o, 160);
  endtask

  task automatic t_deviation();
    set_nom(16'd128);
    chk("R9", "nominal follows input", div_o, 128);
    measure(146, 1'b0, 16'd146, "R5");
    reload_err();
    chk("R8", "error reload to nominal", div_o, 128);
    measure(147, 1'b1, 16'd128, "R5");
    measure(110, 1'b0, 16'd110, "R5");
    measure(147, 1'b1, 16'd110, "R5");
    reload_frame();
    measure(109, 1'b1, 16'd128, "R5");
  endtask

  task automatic t_zero_int();
    set_nom(16'd14);
    measure(15, 1'b1, 16'd14, "R6");
  endtask

  task automatic t_saturate();
    int d0;
    set_nom(16'd160);
    d0 = done_n;
    pulse_brk();
    rx = 1'b0;
    for (int i = 0; i < 5000 && done_n == d0; i++) @(negedge clk);
    rx = 1'b1;
    wait_cyc(2);
    chk("R7", "saturation done", done_n - d0, 1);
    chk("R7", "saturation error", done_err, 1);
    chk("R7", "div unchanged", div_o, 160);
    chk("R7", "busy cleared", busy_o, 0);
  endtask

  task automatic t_abort();
    int d0;
    logic [9:0] pat = 10'b1_0101_0101_0;
    d0 = done_n;
    pulse_brk();
    for (int b = 0; b < 10; b++) begin
      rx = pat[b];
      if (b == 3) begin
        eidle = 1'b1;
        @(negedge clk);
        eidle = 1'b0;
        chk("R8", "abort clears busy", busy_o, 0);
        wait_cyc(99);
      end else wait_cyc(100);
    end
    rx = 1'b1;
    wait_cyc(3);
    chk("R8", "no done after abort", done_n - d0, 0);
    chk("R8", "div nominal after abort", div_o, 160);
  endtask

  task automatic t_disabled();
    int d0;
    logic bm;
    en = 1'b0;
    d0 = done_n;
    pulse_brk();
    send_sync(170, bm);
    chk("R2", "busy ignored when disabled", bm, 0);
    chk("R2", "no done when disabled", done_n - d0, 0);
    chk("R10", "div nominal when disabled", div_o, 160);
    en = 1'b1;
    measure(170, 1'b0, 16'd170, "R10");
    @(negedge clk) en = 1'b0;
    #1;
    chk("R10", "disable shows nominal", div_o, 160);
    reload_frame();
    en = 1'b1;
    wait_cyc(1);
  endtask

  task automatic t_freeze();
    logic [9:0] pat = 10'b1_0101_0101_0;
    pulse_brk();
    for (int b = 0; b < 10; b++) begin
      rx = pat[b];
      if (b == 2) nom = 16'd200;
      wait_cyc(160);
      if (b == 4) chk("R9", "div frozen during measure", div_o, 160);
    end
    rx = 1'b1;
    wait_cyc(3);
    chk("R9", "check against frozen nominal", done_err, 0);
    chk("R9", "measured applied", div_o, 160);
    reload_frame();
    chk("R9", "new nominal after measure", div_o, 200);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_match();
    t_retune();
    t_deviation();
    t_zero_int();
    t_saturate();
    t_abort();
    t_disabled();
    t_freeze();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule